// File: doc/BRIEF.md
# Scaled-Counter Multi-Channel PWM Unit

This block generates several pulse-width-modulated outputs from one shared free-running counter. The period is not set by a period register. A four-bit exponent selects which sixteen-bit window of the counter feeds the comparators, so the period is `2^(16+exponent)` clocks. Each channel compares the windowed count against its own sixteen-bit threshold and drives an active-low output. The output is low while the windowed count is below the threshold. A threshold of zero keeps a channel idle. Because the largest threshold is `0xFFFF`, every period keeps the output high for at least one windowed count.

Software reaches the unit through a plain synchronous register port. Writes take effect at the clock edge and reads are combinational. The counter runs only while a free-run bit or a single-shot bit is set. The single-shot bit clears itself at the end of the period. An optional restart mode shortens the period: the counter returns to zero right after the windowed count meets the threshold of channel 0. Four option bits are stored and read back but have no effect on the counter or the outputs.

Top module: `pwm_scaled_unit`

## Requirements
- R1: After synchronous reset, every register reads zero, the counter does not advance and every output is high.
- R2: The byte map is as follows. Control word at 0x00. Raw counter at 0x08, read/write, 31 bits. Windowed count at 0x10, read-only. Threshold of channel i at 0x20+4*i, 16 bits. Any other address reads zero.
- R3: The control word has these fields: exponent in bits [3:0], option A in bit 8, restart mode in bit 9, option B in bit 10, free-run in bit 12, single-shot in bit 13, option C in bit 16, option D in bit 24, flag E in bit 28. All other bits read as zero. A read after writing all ones returns 0x1101370F.
- R4: The raw counter advances by one per clock while free-run or single-shot is set. With both clear it holds its value. A write to 0x08 loads it.
- R5: The windowed count equals the raw counter shifted right by the exponent, keeping its low 16 bits.
- R6: Each output reflects, one clock later, whether the windowed count was below that channel's threshold (low) or not (high). Over one period the output is low for exactly C windowed counts, where C is the threshold. A threshold of 0 keeps the output high, and the windowed count 0xFFFF always gives high.
- R7: With restart mode clear, a period lasts 2^(16+exponent) clocks. The window wraps from 0xFFFF to 0, including at exponent 15, where the raw counter wraps to 0.
- R8: Single-shot runs the counter until the end of the period and then clears itself, which stops the counter. A write to the control word in the same cycle takes priority.
- R9: With restart mode set, the counter returns to zero on the clock after the windowed count equals channel 0's threshold. This also counts as the end of the period for single-shot.
- R10: A threshold write affects the output from the next clock, in the middle of a period, with no shadow copy.
- R11: Options A, B, C, D and flag E are stored and read back but do not change the counter or any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| pwm_n | output | 4 | Active-low channel outputs |

## Verification
The bench builds the unit with its defaults: four channels, sixteen-bit thresholds and a 31-bit raw counter. Because the raw counter can be written, the bench can place it a few clocks before the end of the period at exponents 2 and 15. This reaches the window wrap, the self-clearing single shot and the full raw-counter rollover without waiting 2^31 clocks. A full exponent-0 period of 65536 clocks is run once to count the low clocks of each channel exactly, with thresholds 0, 3, 0x8000 and 0xFFFF. A behavioural model in the bench follows every clock and catches mixed-setting periods after mid-period threshold writes.

// File: rtl/pwm_scaled_pkg.sv
package pwm_scaled_pkg;

    localparam int DATA_W  = 32;
    localparam int SCALE_W = 4;

    localparam logic [7:0] OFS_CTRL    = 8'h00;
    localparam logic [7:0] OFS_RAW     = 8'h08;
    localparam logic [7:0] OFS_WINDOW  = 8'h10;
    localparam logic [7:0] OFS_THR     = 8'h20;
    localparam int         THR_STRIDE  = 4;

    localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h1101_370F;

    typedef struct packed {
        logic [2:0]         rsv_31_29;
        logic               flag_e;
        logic [2:0]         rsv_27_25;
        logic               opt_d;
        logic [6:0]         rsv_23_17;
        logic               opt_c;
        logic [1:0]         rsv_15_14;
        logic               single_shot;
        logic               free_run;
        logic               rsv_11;
        logic               opt_b;
        logic               restart;
        logic               opt_a;
        logic [3:0]         rsv_7_4;
        logic [SCALE_W-1:0] exponent;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_RAW,
        SEL_WINDOW,
        SEL_THR,
        SEL_NONE
    } reg_sel_e;

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        return ctrl_t'(w & CTRL_KEEP);
    endfunction

    function automatic logic [7:0] thr_offset(input int ch);
        return OFS_THR + 8'(THR_STRIDE * ch);
    endfunction

endpackage

// File: rtl/pwm_scaled_regs.sv
module pwm_scaled_regs
    import pwm_scaled_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CMP_W  = 16,
    parameter int CNT_W  = 31,
    parameter int ADDR_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         period_end,
    input  logic [CNT_W-1:0]             count,
    input  logic [CMP_W-1:0]             window,
    output ctrl_t                        ctrl,
    output logic [NUM_CH-1:0][CMP_W-1:0] thr,
    output logic                         ctrl_wr,
    output logic                         raw_load,
    output logic [DATA_W-1:0]            rd_data
);

    reg_sel_e                sel;
    logic [NUM_CH-1:0]       thr_hit;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_thr
        assign thr_hit[c] = (addr == ADDR_W'(thr_offset(c)));

        always_ff @(posedge clk) begin
            if (rst) begin
                thr[c] <= '0;
            end else if (wr_en && thr_hit[c]) begin
                thr[c] <= wr_data[CMP_W-1:0];
            end
        end
    end

    always_comb begin
        if (addr == ADDR_W'(OFS_CTRL))        sel = SEL_CTRL;
        else if (addr == ADDR_W'(OFS_RAW))    sel = SEL_RAW;
        else if (addr == ADDR_W'(OFS_WINDOW)) sel = SEL_WINDOW;
        else if (|thr_hit)                    sel = SEL_THR;
        else                                  sel = SEL_NONE;
    end

    assign ctrl_wr  = wr_en && (sel == SEL_CTRL);
    assign raw_load = wr_en && (sel == SEL_RAW);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl <= ctrl_from_word(wr_data);
        end else if (period_end) begin
            ctrl.single_shot <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (sel)
            SEL_CTRL:   rd_data = DATA_W'(ctrl);
            SEL_RAW:    rd_data = DATA_W'(count);
            SEL_WINDOW: rd_data = DATA_W'(window);
            SEL_THR: begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (thr_hit[c]) rd_data = DATA_W'(thr[c]);
                end
            end
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/pwm_scaled_timebase.sv
module pwm_scaled_timebase
    import pwm_scaled_pkg::*;
#(
    parameter int CMP_W = 16,
    parameter int CNT_W = 31
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               restart,
    input  logic [SCALE_W-1:0] exponent,
    input  logic [CMP_W-1:0]   thr0,
    input  logic               load,
    input  logic [CNT_W-1:0]   load_val,
    output logic [CNT_W-1:0]   count,
    output logic [CMP_W-1:0]   window,
    output logic               period_end
);

    logic [CNT_W-1:0] frac_mask;
    logic             top_end;
    logic             zero_hit;

    assign window    = CMP_W'(count >> exponent);
    assign frac_mask = (CNT_W'(1) << exponent) - CNT_W'(1);
    assign top_end   = (window == '1) && ((count & frac_mask) == frac_mask);
    assign zero_hit  = restart && (window == thr0);
    assign period_end = run && (zero_hit || top_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (run) begin
            count <= zero_hit ? '0 : count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pwm_scaled_channel.sv
module pwm_scaled_channel #(
    parameter int CMP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CMP_W-1:0] window,
    input  logic [CMP_W-1:0] thr,
    output logic             out_n
);

    logic active;

    assign active = (window < thr);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_n <= 1'b1;
        end else begin
            out_n <= ~active;
        end
    end

endmodule

// File: rtl/pwm_scaled_unit.sv
module pwm_scaled_unit
    import pwm_scaled_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CMP_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0] pwm_n
);

    localparam int CNT_W = CMP_W + (1 << SCALE_W) - 1;

    ctrl_t                        ctrl;
    logic [NUM_CH-1:0][CMP_W-1:0] thr;
    logic                         ctrl_wr;
    logic                         raw_load;
    logic [CNT_W-1:0]             count;
    logic [CMP_W-1:0]             window;
    logic                         period_end;
    logic                         run;

    assign run = ctrl.free_run | ctrl.single_shot;

    pwm_scaled_regs #(
        .NUM_CH (NUM_CH),
        .CMP_W  (CMP_W),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .period_end (period_end),
        .count      (count),
        .window     (window),
        .ctrl       (ctrl),
        .thr        (thr),
        .ctrl_wr    (ctrl_wr),
        .raw_load   (raw_load),
        .rd_data    (rd_data)
    );

    pwm_scaled_timebase #(
        .CMP_W (CMP_W),
        .CNT_W (CNT_W)
    ) u_timebase (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .restart    (ctrl.restart),
        .exponent   (ctrl.exponent),
        .thr0       (thr[0]),
        .load       (raw_load),
        .load_val   (wr_data[CNT_W-1:0]),
        .count      (count),
        .window     (window),
        .period_end (period_end)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm_scaled_channel #(
            .CMP_W (CMP_W)
        ) u_ch (
            .clk    (clk),
            .rst    (rst),
            .window (window),
            .thr    (thr[c]),
            .out_n  (pwm_n[c])
        );
    end

endmodule

// File: rtl/pwm_scaled_unit_chk.sv
module pwm_scaled_unit_chk #(
    parameter int NUM_CH = 4,
    parameter int CMP_W  = 16,
    parameter int CNT_W  = 31
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         run,
    input logic                         restart,
    input logic                         single_shot,
    input logic                         ctrl_wr,
    input logic                         raw_load,
    input logic                         period_end,
    input logic [CNT_W-1:0]             count,
    input logic [CMP_W-1:0]             window,
    input logic [NUM_CH-1:0][CMP_W-1:0] thr,
    input logic [NUM_CH-1:0]            pwm_n
);

    // R4: counter holds while stopped
    a_r4_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run && !raw_load) |=> $stable(count));

    // R4: counter steps by one while running
    a_r4_step_when_running: assert property (@(posedge clk) disable iff (rst)
        (run && !raw_load && !(restart && window == thr[0]))
            |=> count == CNT_W'($past(count) + CNT_W'(1)));

    // R6: top of the window never drives an output low
    a_r6_top_count_inactive: assert property (@(posedge clk) disable iff (rst)
        (window == '1) |=> (&pwm_n));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_idle
        // R6: zero threshold keeps channel idle
        a_r6_zero_thr_idle: assert property (@(posedge clk) disable iff (rst)
            (thr[c] == '0) |=> pwm_n[c]);
    end

    // R8: single shot clears itself at the end of the period
    a_r8_single_shot_clears: assert property (@(posedge clk) disable iff (rst)
        (single_shot && period_end && !ctrl_wr) |=> !single_shot);

    // R9: restart mode returns the counter to zero
    a_r9_restart_to_zero: assert property (@(posedge clk) disable iff (rst)
        (run && restart && window == thr[0] && !raw_load) |=> count == '0);

endmodule

bind pwm_scaled_unit pwm_scaled_unit_chk #(
    .NUM_CH (NUM_CH),
    .CMP_W  (CMP_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .run         (run),
    .restart     (ctrl.restart),
    .single_shot (ctrl.single_shot),
    .ctrl_wr     (ctrl_wr),
    .raw_load    (raw_load),
    .period_end  (period_end),
    .count       (count),
    .window      (window),
    .thr         (thr),
    .pwm_n       (pwm_n)
);

// File: tb/pwm_scaled_unit_test.sv
`timescale 1ns/1ps
module pwm_scaled_unit_test;

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_RAW  = 8'h08;
    localparam logic [7:0] A_WIN  = 8'h10;
    localparam logic [7:0] A_THR0 = 8'h20;
    localparam longint     MASK31 = 64'h7FFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  pwm_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // behavioural reference state
    logic [31:0] m_ctrl;
    longint      m_cnt;
    longint      m_thr [4];
    logic [3:0]  m_out;
    int          m_sc;
    longint      m_win;
    longint      m_nxt;
    bit          m_run, m_zhit, m_pend;

    always #2 clk = ~clk;

    pwm_scaled_unit uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pwm_n   (pwm_n)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = '0;
            m_cnt  = 0;
            for (int i = 0; i < 4; i++) m_thr[i] = 0;
            m_out  = 4'hF;
        end else begin
            m_sc  = int'(m_ctrl[3:0]);
            m_win = (m_cnt >> m_sc) & 64'hFFFF;
            m_run = m_ctrl[12] | m_ctrl[13];
            for (int i = 0; i < 4; i++) m_out[i] = !(m_win < m_thr[i]);
            m_zhit = m_ctrl[9] && (m_win == m_thr[0]);
            m_pend = m_run && (m_zhit ||
                     (((m_cnt + 1) >> (16 + m_sc)) != (m_cnt >> (16 + m_sc))));
            m_nxt = m_cnt;
            if (m_run) m_nxt = m_zhit ? 0 : ((m_cnt + 1) & MASK31);
            if (wr_en && addr == A_RAW) m_nxt = longint'(wr_data) & MASK31;
            if (wr_en && addr == A_CTRL) m_ctrl = wr_data & 32'h1101370F;
            else if (m_pend) m_ctrl[13] = 1'b0;
            for (int i = 0; i < 4; i++)
                if (wr_en && addr == A_THR0 + 8'(4 * i)) m_thr[i] = longint'(wr_data[15:0]);
            m_cnt = m_nxt;
        end
    end

    function automatic longint model_read(input logic [7:0] a);
        if (a == A_CTRL) return longint'(m_ctrl);
        if (a == A_RAW)  return m_cnt;
        if (a == A_WIN)  return (m_cnt >> m_ctrl[3:0]) & 64'hFFFF;
        for (int i = 0; i < 4; i++) if (a == A_THR0 + 8'(4 * i)) return m_thr[i];
        return 0;
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // every clock: outputs versus the reference (R6 R10 R11)
    always @(negedge clk) begin
        if (!rst && !done) check("R6 per-clock output", longint'(pwm_n), longint'(m_out));
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, input string tag, input longint hand);
        addr = a;
        #1;
        check(tag, longint'(rd_data), hand);
        check({tag, " model"}, longint'(rd_data), model_read(a));
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int low [4];
        idle(4);
        rst = 1'b0;

        // R1 reset state
        rd(A_CTRL, "R1 ctrl after reset", 0);
        rd(A_RAW, "R1 raw after reset", 0);
        for (int i = 0; i < 4; i++) rd(A_THR0 + 8'(4 * i), "R1 thr after reset", 0);
        check("R1 outputs after reset", longint'(pwm_n), 4'hF);
        idle(10);
        rd(A_RAW, "R1 counter stopped", 0);

        // R2 R3 field layout
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, "R3 reserved bits zero", 64'h1101370F);
        wr(A_CTRL, 32'h0);
        rd(8'h04, "R2 unmapped read", 0);
        wr(A_THR0 + 8'h8, 32'hABCD_1234);
        rd(A_THR0 + 8'h8, "R2 threshold 16 bits", 64'h1234);
        wr(A_THR0 + 8'h8, 32'h0);

        // R4 hold while stopped, load
        wr(A_RAW, 32'h0000_1234);
        idle(20);
        rd(A_RAW, "R4 hold when stopped", 64'h1234);

        // R5 window
        wr(A_CTRL, 32'h0000_0003);
        wr(A_RAW, 32'h0001_2345);
        rd(A_WIN, "R5 window exponent 3", 64'h2468);

        // R6 R7 full exponent-0 period
        wr(A_CTRL, 32'h0);
        wr(A_THR0 + 8'h0, 32'h0);
        wr(A_THR0 + 8'h4, 32'h3);
        wr(A_THR0 + 8'h8, 32'h8000);
        wr(A_THR0 + 8'hC, 32'hFFFF);
        wr(A_RAW, 32'h0);
        wr(A_CTRL, 32'h0000_1000);
        for (int i = 0; i < 4; i++) low[i] = 0;
        repeat (65536) begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) if (!pwm_n[i]) low[i]++;
        end
        check("R6 low clocks thr 0", low[0], 0);
        check("R6 low clocks thr 3", low[1], 3);
        check("R6 low clocks thr 0x8000", low[2], 32768);
        check("R6 low clocks thr 0xFFFF", low[3], 65535);
        rd(A_RAW, "R7 period length exp 0", 64'h10000);
        rd(A_WIN, "R7 window wrapped", 0);

        // R10 mid-period threshold write
        wr(A_THR0 + 8'h4, 32'h100);
        wr(A_RAW, 32'h80);
        idle(3);
        check("R10 low before rewrite", longint'(pwm_n[1]), 0);
        wr(A_THR0 + 8'h4, 32'h40);
        idle(1);
        check("R10 new threshold applied", longint'(pwm_n[1]), 1);

        // R8 single shot, exponent 2
        wr(A_CTRL, 32'h0);
        wr(A_RAW, 32'h0003_FFF0);
        wr(A_CTRL, 32'h0000_2002);
        idle(40);
        rd(A_RAW, "R8 stops after wrap", 64'h40000);
        rd(A_CTRL, "R8 single shot cleared", 64'h2);

        // R7 exponent 15 raw rollover
        wr(A_CTRL, 32'h0000_000F);
        wr(A_RAW, 32'h7FFF_FFF0);
        rd(A_WIN, "R5 window exponent 15", 64'hFFFF);
        wr(A_CTRL, 32'h0000_200F);
        idle(40);
        rd(A_RAW, "R7 raw rollover exp 15", 0);
        rd(A_CTRL, "R8 cleared at exp 15", 64'hF);

        // R9 restart mode
        wr(A_CTRL, 32'h0);
        wr(A_THR0 + 8'h0, 32'd10);
        wr(A_RAW, 32'h0);
        wr(A_CTRL, 32'h0000_1200);
        idle(25);
        rd(A_RAW, "R9 restart period 11", 3);
        wr(A_CTRL, 32'h0);
        wr(A_RAW, 32'h0);
        wr(A_CTRL, 32'h0000_2200);
        idle(30);
        rd(A_RAW, "R9 single shot restart stops", 0);
        rd(A_CTRL, "R9 single shot cleared", 64'h200);

        // R11 inert options
        wr(A_CTRL, 32'h0);
        wr(A_THR0 + 8'h0, 32'h0);
        wr(A_THR0 + 8'h8, 32'h20);
        wr(A_RAW, 32'h0);
        wr(A_CTRL, 32'h1101_1500);
        rd(A_CTRL, "R11 options read back", 64'h11011500);
        low[2] = 0;
        repeat (64) begin
            @(negedge clk);
            if (!pwm_n[2]) low[2]++;
        end
        check("R11 options leave duty unchanged", low[2], 32);
        rd(A_RAW, "R11 options leave counter unchanged", 64);

        idle(4);
        finish_run();
    end

endmodule